// File: doc/BRIEF.md
# Bounded posit decoder

This block turns one packed word in the bounded-posit number format into separate fields that an arithmetic datapath can consume directly. The outputs are a sign bit, a flag for zero, a flag for the not-a-real code, a signed binary scale, and a significand with the hidden one written out. The word width is a parameter (default 32, legal for any width above 12). The regime run is capped at six bits and the exponent field is always five bits wide. Because of that cap, the regime length takes one of only five values, and field extraction reduces to a five-way multiplexer over fixed shifts.

The decode is a single combinational cone, and its result is registered once. The block therefore accepts a new word every cycle and presents its fields one clock later. A negative word is turned back into its magnitude by a two's complement of the whole word before the fields are read, so the datapath always sees a positive significand and a separate sign.

Top module: `bposit_decoder`

## Requirements
- R1: `sign_o` equals bit WIDTH-1 of the word sampled at the previous rising clock edge, so every output lags the input by exactly one cycle.
- R2: The all-zero word sets `zero_o`=1 and `nar_o`=0, and drives `sign_o`, `scale_o` and `frac_o` to 0.
- R3: A word with only bit WIDTH-1 set sets `nar_o`=1, `zero_o`=0 and `sign_o`=1, and drives `scale_o` and `frac_o` to 0.
- R4: A word with bit WIDTH-1 set (other than the not-a-real code) is negated in two's complement over the whole word before decoding, so the words w and -w give the same `scale_o` and `frac_o` and differ only in `sign_o`.
- R5: The regime starts at bit WIDTH-2. A run of m ones (1 <= m <= 5) followed by a zero terminator gives a regime value of m-1. The terminator is not part of any later field.
- R6: A run of m zeros (1 <= m <= 5) followed by a one terminator gives a regime value of -m, and the terminator is skipped.
- R7: A run reaching six identical bits ends the regime with no terminator. It gives a regime value of 5 for ones or -6 for zeros, and the exponent starts at the very next bit.
- R8: The 5 bits after the regime form an unsigned exponent e. `scale_o` is a two's-complement value equal to 32*regime + e, always in the range -192 to 191.
- R9: `frac_o` is WIDTH-7 bits wide. Its MSB is the hidden 1 for every non-special word. All bits left after the exponent follow the hidden 1 in order, and zeros fill the low end.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_i | input | WIDTH | Packed bounded-posit word |
| sign_o | output | 1 | Sign of the decoded value |
| zero_o | output | 1 | Word was the zero code |
| nar_o | output | 1 | Word was the not-a-real code |
| scale_o | output | 9 | Signed power-of-two scale, 32*regime + exponent |
| frac_o | output | WIDTH-7 | Significand with explicit hidden 1, left aligned |

## Verification
The assertions take for granted that `word_i` is a defined value at every rising edge once reset is released. The sign check compares the registered sign with the input word one edge earlier, so it relies on the input being held stable around the edge. The bench sets the input only on falling edges and holds it through the following rising edge. The bench then walks both signs, both run polarities, every run length from one to six and all 32 exponent codes, with random bits filling the fraction. This keeps every word inside the defined encodings, and the two special codes are applied only as directed cases.

// File: rtl/bposit_pkg.sv
package bposit_pkg;

    // Polarity of the leading regime run
    typedef enum logic {
        RUN_ZEROS = 1'b0,
        RUN_ONES  = 1'b1
    } run_pol_e;

    // Format constants shared by the decoder hierarchy
    localparam int unsigned BP_EXP_BITS = 5;
    localparam int unsigned BP_RUN_MAX  = 6;

endpackage

// File: rtl/bposit_run_detect.sv
module bposit_run_detect
    import bposit_pkg::*;
#(
    parameter int unsigned RUN_MAX = BP_RUN_MAX,
    localparam int unsigned LEN_W  = $clog2(RUN_MAX + 1)
) (
    input  logic [RUN_MAX-1:0] head_i,   // top RUN_MAX bits of the body
    output run_pol_e           pol_o,
    output logic [LEN_W-1:0]   len_o     // run length, 1..RUN_MAX
);

    logic alive;

    always_comb begin
        pol_o = run_pol_e'(head_i[RUN_MAX-1]);
        len_o = '0;
        alive = 1'b1;
        for (int i = 0; i < RUN_MAX; i++) begin
            if (alive && (head_i[RUN_MAX-1-i] == head_i[RUN_MAX-1])) begin
                len_o = len_o + LEN_W'(1);
            end else begin
                alive = 1'b0;
            end
        end
    end

endmodule

// File: rtl/bposit_field_mux.sv
module bposit_field_mux #(
    parameter int unsigned BODY_W  = 31,
    parameter int unsigned RUN_MAX = 6,
    localparam int unsigned LEN_W  = $clog2(RUN_MAX + 1)
) (
    input  logic [BODY_W-1:0] body_i,
    input  logic [LEN_W-1:0]  run_len_i,
    output logic [BODY_W-1:0] aligned_o   // exponent now at the top
);

    // Regime bits consumed: run plus terminator, or RUN_MAX when capped
    logic [LEN_W-1:0]  consumed;
    logic [BODY_W-1:0] cand [2:RUN_MAX];

    always_comb begin
        if (run_len_i == LEN_W'(RUN_MAX)) begin
            consumed = LEN_W'(RUN_MAX);
        end else begin
            consumed = run_len_i + LEN_W'(1);
        end
    end

    // One fixed shift per legal regime length
    for (genvar g = 2; g <= RUN_MAX; g++) begin : g_shift
        assign cand[g] = body_i << g;
    end

    always_comb begin
        aligned_o = cand[2];
        for (int k = 2; k <= RUN_MAX; k++) begin
            if (consumed == LEN_W'(k)) begin
                aligned_o = cand[k];
            end
        end
    end

endmodule

// File: rtl/bposit_decoder.sv
module bposit_decoder
    import bposit_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter int unsigned EXP_W   = BP_EXP_BITS,
    parameter int unsigned RUN_MAX = BP_RUN_MAX,
    localparam int unsigned BODY_W  = WIDTH - 1,
    localparam int unsigned FBITS   = WIDTH - 1 - EXP_W - 2,
    localparam int unsigned FRAC_W  = FBITS + 1,
    localparam int unsigned LEN_W   = $clog2(RUN_MAX + 1),
    localparam int unsigned RV_W    = $clog2(RUN_MAX) + 1,
    localparam int unsigned SCALE_W = RV_W + EXP_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WIDTH-1:0]   word_i,
    output logic               sign_o,
    output logic               zero_o,
    output logic               nar_o,
    output logic [SCALE_W-1:0] scale_o,
    output logic [FRAC_W-1:0]  frac_o
);

    localparam int SCALE_MIN = -(int'(RUN_MAX) * (1 << EXP_W));
    localparam int SCALE_MAX = (int'(RUN_MAX) * (1 << EXP_W)) - 1;

    typedef struct packed {
        logic               sign;
        logic               zero;
        logic               nar;
        logic [SCALE_W-1:0] scale;
        logic [FRAC_W-1:0]  frac;
    } dec_t;

    dec_t dec_d, dec_q;

    logic [WIDTH-1:0]        mag;
    logic [BODY_W-1:0]       body;
    run_pol_e                run_pol;
    logic [LEN_W-1:0]        run_len;
    logic [BODY_W-1:0]       aligned;
    logic signed [RV_W-1:0]  regime;
    logic                    is_zero;
    logic                    is_nar;

    // Magnitude: two's complement of the whole word when negative
    always_comb begin
        if (word_i[WIDTH-1]) begin
            mag = ~word_i + WIDTH'(1);
        end else begin
            mag = word_i;
        end
        body = mag[BODY_W-1:0];
    end

    bposit_run_detect #(
        .RUN_MAX (RUN_MAX)
    ) u_run (
        .head_i (body[BODY_W-1 -: RUN_MAX]),
        .pol_o  (run_pol),
        .len_o  (run_len)
    );

    bposit_field_mux #(
        .BODY_W  (BODY_W),
        .RUN_MAX (RUN_MAX)
    ) u_mux (
        .body_i    (body),
        .run_len_i (run_len),
        .aligned_o (aligned)
    );

    // Next-state computation
    always_comb begin
        is_zero = (word_i == '0);
        is_nar  = (word_i == {1'b1, {BODY_W{1'b0}}});

        if (run_pol == RUN_ONES) begin
            regime = RV_W'({1'b0, run_len}) - RV_W'(1);
        end else begin
            regime = -RV_W'({1'b0, run_len});
        end

        dec_d.sign = word_i[WIDTH-1];
        dec_d.zero = is_zero;
        dec_d.nar  = is_nar;
        // scale = regime * 2^EXP_W + exponent, a plain concatenation
        dec_d.scale = {regime, aligned[BODY_W-1 -: EXP_W]};
        dec_d.frac  = {1'b1, aligned[BODY_W-1-EXP_W -: FBITS]};

        if (is_zero || is_nar) begin
            dec_d.scale = '0;
            dec_d.frac  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign sign_o  = dec_q.sign;
    assign zero_o  = dec_q.zero;
    assign nar_o   = dec_q.nar;
    assign scale_o = dec_q.scale;
    assign frac_o  = dec_q.frac;

    AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sign_o == $past(word_i[WIDTH-1]))); // R1

    AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        zero_o |-> (!nar_o && !sign_o && scale_o == '0 && frac_o == '0)); // R2

    AST_NAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        nar_o |-> (!zero_o && sign_o && scale_o == '0 && frac_o == '0)); // R3

    AST_SCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(scale_o) >= SCALE_MIN) && ($signed(scale_o) <= SCALE_MAX)); // R8

    AST_HIDDEN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !zero_o && !nar_o |-> frac_o[FRAC_W-1]); // R9

endmodule

// File: tb/tb_bposit_decoder.sv
`timescale 1ns/1ps
module tb_bposit_decoder;

    localparam int W   = 32;
    localparam int FW  = W - 7;
    localparam int SW  = 9;
    localparam int NV  = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  word_i = '0;
    logic          sign_o, zero_o, nar_o;
    logic [SW-1:0] scale_o;
    logic [FW-1:0] frac_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bposit_decoder #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .word_i(word_i),
        .sign_o(sign_o), .zero_o(zero_o), .nar_o(nar_o),
        .scale_o(scale_o), .frac_o(frac_o)
    );

    // Hand-worked vectors: word, expected scale, expected significand
    localparam logic [W-1:0] VEC_WORD [NV] = '{
        32'h4000_0000, 32'h7FFF_FFFF, 32'h0000_0001, 32'hC000_0000,
        32'h2000_0000, 32'h6000_0000, 32'h4800_0000};
    localparam int VEC_SCALE [NV] = '{0, 191, -192, 0, -32, 32, 8};
    localparam logic [FW-1:0] VEC_FRAC [NV] = '{
        25'h100_0000, 25'h1FF_FFF0, 25'h100_0010, 25'h100_0000,
        25'h100_0000, 25'h100_0000, 25'h100_0000};
    localparam string VEC_TAG [NV] = '{"R5", "R7", "R7", "R4", "R6", "R5", "R8"};

    // Behavioural reference: bit-serial scan of the word
    task automatic ref_model(input logic [W-1:0] w, output bit s, output bit z,
                             output bit n, output int sc, output logic [FW-1:0] f);
        logic [W-1:0] a;
        bit lead;
        int m, pos, e, r;
        s = w[W-1]; z = (w == '0); n = (w == {1'b1, {(W-1){1'b0}}});
        sc = 0; f = '0;
        if (z || n) return;
        a = s ? (~w + 1'b1) : w;
        lead = a[W-2];
        m = 0;
        for (int i = W - 2; i >= W - 7; i--) begin
            if (a[i] == lead) m++; else break;
        end
        pos = W - 2 - m;
        if (m < 6) pos--;
        r = lead ? m - 1 : -m;
        e = 0;
        for (int k = 0; k < 5; k++) e = e * 2 + int'(a[pos - k]);
        sc = r * 32 + e;
        f[FW-1] = 1'b1;
        for (int k = 0; k < pos - 4; k++) f[FW-2-k] = a[pos - 5 - k];
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [W-1:0] w);
        @(negedge clk);
        word_i = w;
        @(negedge clk);
    endtask

    task automatic run_vec(input logic [W-1:0] w, input string tag);
        bit es, ez, en;
        int esc;
        logic [FW-1:0] ef;
        ref_model(w, es, ez, en, esc, ef);
        apply(w);
        check(sign_o == es, "R1", {tag, " sign"}, int'(sign_o), int'(es));
        check(zero_o == ez, "R2", {tag, " zero"}, int'(zero_o), int'(ez));
        check(nar_o == en, "R3", {tag, " nar"}, int'(nar_o), int'(en));
        check(int'($signed(scale_o)) == esc, "R8", {tag, " scale"},
              int'($signed(scale_o)), esc);
        check(frac_o == ef, "R9", {tag, " frac"}, int'(frac_o), int'(ef));
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: outputs held at zero during reset even with a live input
        word_i = 32'h7FFF_FFFF;
        repeat (3) @(negedge clk);
        check({sign_o, zero_o, nar_o, scale_o, frac_o} == '0, "R10", "reset outputs",
              int'(frac_o), 0);
        rst_n = 1'b1;

        // Table walk, compared against hand-computed values
        for (int v = 0; v < NV; v++) begin
            apply(VEC_WORD[v]);
            check(int'($signed(scale_o)) == VEC_SCALE[v], VEC_TAG[v], "table scale",
                  int'($signed(scale_o)), VEC_SCALE[v]);
            check(frac_o == VEC_FRAC[v], VEC_TAG[v], "table frac",
                  int'(frac_o), int'(VEC_FRAC[v]));
            check(sign_o == VEC_WORD[v][W-1], "R1", "table sign",
                  int'(sign_o), int'(VEC_WORD[v][W-1]));
        end

        // R2 and R3: the two special codes
        apply('0);
        check(zero_o && !nar_o && !sign_o && scale_o == '0 && frac_o == '0, "R2",
              "zero code", int'(zero_o), 1);
        apply({1'b1, {(W-1){1'b0}}});
        check(nar_o && !zero_o && sign_o && scale_o == '0 && frac_o == '0, "R3",
              "nar code", int'(nar_o), 1);

        // Sweep: sign x run polarity x run length x exponent, random fraction
        for (int sg = 0; sg < 2; sg++) begin
            for (int ld = 0; ld < 2; ld++) begin
                for (int m = 1; m <= 6; m++) begin
                    for (int e = 0; e < 32; e++) begin
                        logic [W-2:0] body;
                        logic [W-1:0] w;
                        int p;
                        string tag;
                        body = (W-1)'($urandom);
                        for (int i = 0; i < m; i++) body[W-2-i] = ld[0];
                        if (m < 6) body[W-2-m] = ~ld[0];
                        p = (m < 6) ? W - 3 - m : W - 8;
                        for (int k = 0; k < 5; k++) body[p-k] = e[4-k];
                        w = {1'b0, body};
                        if (sg == 1) w = ~w + 1'b1;
                        tag = (m == 6) ? "R7" : (ld == 1 ? "R5" : "R6");
                        if (sg == 1) tag = {tag, "/R4"};
                        run_vec(w, tag);
                    end
                end
            end
        end

        // R4: w and -w decode to the same magnitude fields
        for (int t = 0; t < 16; t++) begin
            logic [W-1:0] w;
            logic [SW-1:0] sc_p;
            logic [FW-1:0] fr_p;
            w = {1'b0, (W-1)'($urandom)};
            if (w == '0) w = 32'h1234_5678;
            apply(w);
            sc_p = scale_o; fr_p = frac_o;
            apply(~w + 1'b1);
            check(scale_o == sc_p && frac_o == fr_p && sign_o, "R4", "negation symmetry",
                  int'($signed(scale_o)), int'($signed(sc_p)));
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule